// File: doc/BRIEF.md
# Masked LUT Unit for a Condition Register

This block applies a programmable truth table to bits of a condition register that is split into 4-bit fields. The register holds `NUM_FIELDS` fields. Bits are numbered MSB0: bit 0 is the most significant bit of the register. There are four operations. Two of them change a single bit. The other two change a whole field under a per-bit mask. Each table lookup uses the old value of the destination as one of its inputs. So the same hardware can express set, clear, toggle, and any merge of up to three operands.

The surrounding pipeline presents the current register value together with an operation. One cycle later the block returns the whole new register value. In that value, only the bits that the operation targets can differ from the input. Every source bit and source field is taken from the presented value. So when a source is also the destination, the lookup uses the old contents.

Top module: `cr_lut_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `out_valid` = 0 and `cr_out` = 0.
- R2: `out_valid` follows `in_valid` by exactly one cycle. When `in_valid` is 0, `cr_out` holds its previous value.
- R3: Single-bit ternary operation (`op` = 0). Form the index as b + 2·a + 4·t, where t, a and b are the bits at `tgt_sel`, `a_sel` and `b_sel`. The target bit becomes `imm_lut[7 - index]`.
- R4: Single-bit binary operation (`op` = 1). Form the index as a + 2·t, from the bits at `a_sel` and `tgt_sel`. The table is the value of field `b_sel` modulo `NUM_FIELDS`. The target bit becomes table bit (3 - index), where table bit 0 has weight 1.
- R5: Field ternary operation (`op` = 2). The destination field D is `tgt_sel`, and the source fields A and B are `a_sel` and `b_sel`, all taken modulo `NUM_FIELDS`. For each bit i where `fld_mask[i]` = 1, the new D[i] is `imm_lut[7 - (B[i] + 2·A[i] + 4·D[i])]`.
- R6: Field binary operation (`op` = 3). The table is the value of field `b_sel`. For each bit i where `fld_mask[i]` = 1, the new D[i] is table bit (3 - (A[i] + 2·D[i])).
- R7: In the field operations, each destination bit i with `fld_mask[i]` = 0 keeps its prior value. With a mask of 0, the register is returned unchanged.
- R8: Every register bit outside the target bit or the destination field leaves the block unchanged.
- R9: A source that names the destination bit or the destination field supplies its value from before the update.
- R10: Bit n of the register is `cr_in[31 - n]` (for 8 fields). Field k covers bits 4k to 4k+3. Bit 4k carries weight 8 within the field value, and field bit i is the bit with weight 2^i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 0 bit ternary, 1 bit binary, 2 field ternary, 3 field binary |
| cr_in | input | 4·NUM_FIELDS | Current register value |
| tgt_sel | input | log2(4·NUM_FIELDS) | Target bit number, or destination field number in its low bits |
| a_sel | input | log2(4·NUM_FIELDS) | Source A bit number or field number |
| b_sel | input | log2(4·NUM_FIELDS) | Source B bit number, or field number of B or of the table |
| imm_lut | input | 8 | Ternary truth table |
| fld_mask | input | 4 | Per-bit write mask for the field operations |
| out_valid | output | 1 | `cr_out` holds the result of the operation from the previous cycle |
| cr_out | output | 4·NUM_FIELDS | Updated register value |

## Verification
The bench uses the default of eight fields, which gives a 32-bit register. At that size every bit position and every field can be reached as a target, as a source and as a table. For the single-bit ternary form, the bench sweeps all 256 immediates against all eight input combinations. For the field ternary form, it sweeps every immediate against every mask. For the field binary form, it sweeps every destination, source and table value against a rotating mask. It also applies deliberate aliasing of sources onto the destination and checks the hold behaviour between operations.

// File: rtl/cr_lut_pkg.sv
// Package: operation codes and fixed geometry for the masked LUT unit.
// Assumes four bits per field; the binary table is one field wide.
package cr_lut_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        OP_BIT_TERN = 2'd0,
        OP_BIT_BIN  = 2'd1,
        OP_FLD_TERN = 2'd2,
        OP_FLD_BIN  = 2'd3
    } lut_op_e;

endpackage

// File: rtl/cr_field_read.sv
// Field reader: returns the 4-bit value of field SEL of a register
// numbered MSB0, so field 0 sits in the top nibble.
// Assumes NUM_FIELDS is a power of two.
module cr_field_read #(
    parameter int NUM_FIELDS = 8,
    localparam int FW        = cr_lut_pkg::FIELD_W,
    localparam int CR_W      = NUM_FIELDS * FW,
    localparam int FSEL_W    = $clog2(NUM_FIELDS)
) (
    input  logic [CR_W-1:0]   cr,
    input  logic [FSEL_W-1:0] sel,
    output logic [FW-1:0]     val
);

    // Mux the selected nibble out of the register.
    always_comb begin
        val = '0;
        for (int k = 0; k < NUM_FIELDS; k++) begin
            if (sel == FSEL_W'(k)) begin
                val = cr[CR_W-1-FW*k -: FW];
            end
        end
    end

endmodule

// File: rtl/cr_bit_lut.sv
// Single-bit lookup: picks one bit out of the 8-entry immediate table
// (ternary form) or out of the 4-entry field table (binary form).
// The table index is inverted because entry 0 is the most significant bit.
module cr_bit_lut (
    input  logic       use_bin,
    input  logic       t_bit,
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic [7:0] imm,
    input  logic [3:0] table4,
    output logic       res
);

    logic [2:0] idx3;
    logic [1:0] idx2;

    // Build both indices and select the bit of the active table.
    always_comb begin
        idx3 = {t_bit, a_bit, b_bit};
        idx2 = {t_bit, a_bit};
        res  = use_bin ? table4[~idx2] : imm[~idx3];
    end

endmodule

// File: rtl/cr_field_lut.sv
// Field-wide lookup: one lookup lane per field bit, and a mask that
// keeps the old destination bit wherever the mask bit is zero.
module cr_field_lut #(
    localparam int FW = cr_lut_pkg::FIELD_W
) (
    input  logic          use_bin,
    input  logic [FW-1:0] dst,
    input  logic [FW-1:0] src_a,
    input  logic [FW-1:0] src_b,
    input  logic [7:0]    imm,
    input  logic [FW-1:0] table4,
    input  logic [FW-1:0] mask,
    output logic [FW-1:0] res
);

    for (genvar i = 0; i < FW; i++) begin : g_lane
        logic lane_bit;

        cr_bit_lut u_lane (
            .use_bin (use_bin),
            .t_bit   (dst[i]),
            .a_bit   (src_a[i]),
            .b_bit   (src_b[i]),
            .imm     (imm),
            .table4  (table4),
            .res     (lane_bit)
        );

        // Merge the lookup result under the mask.
        always_comb begin
            res[i] = mask[i] ? lane_bit : dst[i];
        end
    end

endmodule

// File: rtl/cr_lut_unit.sv
// Masked LUT unit for a condition register made of NUM_FIELDS 4-bit fields.
// It reads all sources from cr_in, computes either one bit or one masked
// field, and registers the whole updated register for one cycle.
// Assumes NUM_FIELDS is a power of two. Field operations use the low bits of
// the select inputs.
module cr_lut_unit #(
    parameter int NUM_FIELDS = 8,
    localparam int FW        = cr_lut_pkg::FIELD_W,
    localparam int CR_W      = NUM_FIELDS * FW,
    localparam int BSEL_W    = $clog2(CR_W),
    localparam int FSEL_W    = $clog2(NUM_FIELDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [CR_W-1:0]   cr_in,
    input  logic [BSEL_W-1:0] tgt_sel,
    input  logic [BSEL_W-1:0] a_sel,
    input  logic [BSEL_W-1:0] b_sel,
    input  logic [7:0]        imm_lut,
    input  logic [FW-1:0]     fld_mask,
    output logic              out_valid,
    output logic [CR_W-1:0]   cr_out
);
    import cr_lut_pkg::*;

    lut_op_e           op_e;
    logic              is_bin;
    logic              is_field;
    logic [BSEL_W-1:0] tgt_pos;
    logic [BSEL_W-1:0] a_pos;
    logic [BSEL_W-1:0] b_pos;
    logic              t_bit, a_bit, b_bit;
    logic              bit_res;
    logic [FW-1:0]     dst_fld, a_fld, b_fld;
    logic [FW-1:0]     fld_res;
    logic [FSEL_W-1:0] dst_idx;
    logic [CR_W-1:0]   cr_next;

    // Decode the operation into its table kind and its width.
    always_comb begin
        op_e     = lut_op_e'(op);
        is_bin   = (op_e == OP_BIT_BIN) || (op_e == OP_FLD_BIN);
        is_field = (op_e == OP_FLD_TERN) || (op_e == OP_FLD_BIN);
        dst_idx  = tgt_sel[FSEL_W-1:0];
    end

    // Translate MSB0 bit numbers into vector positions and read the bits.
    always_comb begin
        tgt_pos = BSEL_W'(CR_W - 1) - tgt_sel;
        a_pos   = BSEL_W'(CR_W - 1) - a_sel;
        b_pos   = BSEL_W'(CR_W - 1) - b_sel;
        t_bit   = cr_in[tgt_pos];
        a_bit   = cr_in[a_pos];
        b_bit   = cr_in[b_pos];
    end

    cr_field_read #(.NUM_FIELDS(NUM_FIELDS)) u_rd_dst (
        .cr  (cr_in),
        .sel (dst_idx),
        .val (dst_fld)
    );

    cr_field_read #(.NUM_FIELDS(NUM_FIELDS)) u_rd_a (
        .cr  (cr_in),
        .sel (a_sel[FSEL_W-1:0]),
        .val (a_fld)
    );

    cr_field_read #(.NUM_FIELDS(NUM_FIELDS)) u_rd_b (
        .cr  (cr_in),
        .sel (b_sel[FSEL_W-1:0]),
        .val (b_fld)
    );

    // Single-bit path: the binary table is the field named by b_sel.
    cr_bit_lut u_bit (
        .use_bin (is_bin),
        .t_bit   (t_bit),
        .a_bit   (a_bit),
        .b_bit   (b_bit),
        .imm     (imm_lut),
        .table4  (b_fld),
        .res     (bit_res)
    );

    // Field path: for the binary form, field B is the table.
    cr_field_lut u_fld (
        .use_bin (is_bin),
        .dst     (dst_fld),
        .src_a   (a_fld),
        .src_b   (b_fld),
        .imm     (imm_lut),
        .table4  (b_fld),
        .mask    (fld_mask),
        .res     (fld_res)
    );

    // Write back only the target bit or the destination field.
    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_fld
        for (genvar j = 0; j < FW; j++) begin : g_bit
            localparam int VPOS = CR_W - 1 - FW * k - (FW - 1 - j);
            always_comb begin
                if (is_field) begin
                    cr_next[VPOS] = (dst_idx == FSEL_W'(k)) ? fld_res[j] : cr_in[VPOS];
                end else begin
                    cr_next[VPOS] = (tgt_pos == BSEL_W'(VPOS)) ? bit_res : cr_in[VPOS];
                end
            end
        end
    end

    // Output register: clears on reset, loads on a valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cr_out    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cr_out <= cr_next;
            end
        end
    end

endmodule

// File: rtl/cr_lut_unit_chk.sv
// Checker for cr_lut_unit: covers timing, hold, and which bits may change.
// It is attached to every instance through the bind below.
module cr_lut_unit_chk #(
    parameter int NUM_FIELDS = 8,
    localparam int FW        = 4,
    localparam int CR_W      = NUM_FIELDS * FW,
    localparam int BSEL_W    = $clog2(CR_W),
    localparam int FSEL_W    = $clog2(NUM_FIELDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op,
    input logic [CR_W-1:0]   cr_in,
    input logic [BSEL_W-1:0] tgt_sel,
    input logic [BSEL_W-1:0] a_sel,
    input logic [BSEL_W-1:0] b_sel,
    input logic [7:0]        imm_lut,
    input logic [FW-1:0]     fld_mask,
    input logic              out_valid,
    input logic [CR_W-1:0]   cr_out
);

    logic [CR_W-1:0] region;
    logic [CR_W-1:0] masked;

    // Bits of the destination field, and the masked subset of them.
    always_comb begin
        region = '0;
        masked = '0;
        for (int k = 0; k < NUM_FIELDS; k++) begin
            if (tgt_sel[FSEL_W-1:0] == FSEL_W'(k)) begin
                region[CR_W-1-FW*k -: FW] = '1;
                masked[CR_W-1-FW*k -: FW] = fld_mask;
            end
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && cr_out == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cr_out));

    a_r8_single_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op[1]) |=> ($countones(cr_out ^ $past(cr_in)) <= 1));

    a_r8_field_region: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[1]) |=> (((cr_out ^ $past(cr_in)) & ~$past(region)) == '0));

    a_r7_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[1]) |=> (((cr_out ^ $past(cr_in)) & ~$past(masked)) == '0));

    a_r7_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[1] && fld_mask == '0) |=> (cr_out == $past(cr_in)));

endmodule

bind cr_lut_unit cr_lut_unit_chk #(.NUM_FIELDS(NUM_FIELDS)) u_chk (.*);

// File: tb/cr_lut_unit_test.sv
`timescale 1ns/1ps
module cr_lut_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic [31:0] cr_in = '0;
    logic [4:0]  tgt_sel = '0, a_sel = '0, b_sel = '0;
    logic [7:0]  imm_lut = '0;
    logic [3:0]  fld_mask = '0;
    logic        out_valid;
    logic [31:0] cr_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cr_lut_unit #(.NUM_FIELDS(8)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cr_in(cr_in),
        .tgt_sel(tgt_sel), .a_sel(a_sel), .b_sel(b_sel), .imm_lut(imm_lut),
        .fld_mask(fld_mask), .out_valid(out_valid), .cr_out(cr_out)
    );

    function automatic logic [3:0] fld(logic [31:0] cr, int k);
        return cr[31 - 4*(k % 8) -: 4];
    endfunction

    // Expected register value, computed from the MSB0 rules.
    function automatic logic [31:0] model(int o, logic [31:0] cr, int t, int a, int b,
                                          logic [7:0] imm, logic [3:0] m);
        logic [31:0] r = cr;
        logic [3:0] d, fa, fb, nd;
        int idx;
        d = fld(cr, t); fa = fld(cr, a); fb = fld(cr, b); nd = d;
        case (o)
            0: begin
                idx = int'(cr[31-b]) + 2*int'(cr[31-a]) + 4*int'(cr[31-t]);
                r[31-t] = imm[7-idx];
            end
            1: begin
                idx = int'(cr[31-a]) + 2*int'(cr[31-t]);
                r[31-t] = fb[3-idx];
            end
            default: begin
                for (int i = 0; i < 4; i++) begin
                    if (m[i]) begin
                        if (o == 2) nd[i] = imm[7 - (int'(fb[i]) + 2*int'(fa[i]) + 4*int'(d[i]))];
                        else        nd[i] = fb[3 - (int'(fa[i]) + 2*int'(d[i]))];
                    end
                end
                r[31 - 4*(t % 8) -: 4] = nd;
            end
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one operation and compare the registered result.
    task automatic run(string tag, int o, logic [31:0] cr, int t, int a, int b,
                       logic [7:0] imm, logic [3:0] m);
        @(negedge clk);
        in_valid = 1'b1; op = 2'(o); cr_in = cr;
        tgt_sel = 5'(t); a_sel = 5'(a); b_sel = 5'(b);
        imm_lut = imm; fld_mask = m;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, cr_out, model(o, cr, t, a, b, imm, m));
        check("R2 valid", {31'b0, out_valid}, 32'd1);
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] cr;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R1 valid", {31'b0, out_valid}, 32'd0);
        check("R1 data", cr_out, 32'd0);
        rst_n = 1'b1;

        // R10: field 0 = 4'b1000 as table, bits 5 and 6 zero -> bit 5 set.
        run("R10", 1, 32'h8000_0000, 5, 6, 0, 8'h00, 4'h0);
        check("R10 constant", cr_out, 32'h8400_0000);

        // R3: every immediate against every input combination.
        for (int imm = 0; imm < 256; imm++) begin
            for (int c = 0; c < 8; c++) begin
                int t = (imm * 7 + c * 3) % 32;
                int a = (t + 1 + imm % 15) % 32;
                int b = (t + 16 + c) % 32;
                cr = $urandom;
                cr[31-t] = c[2]; cr[31-a] = c[1]; cr[31-b] = c[0];
                run("R3/R8", 0, cr, t, a, b, 8'(imm), 4'($urandom));
            end
        end

        // R4: every table field, table value and input pair.
        for (int f = 0; f < 8; f++) begin
            for (int v = 0; v < 16; v++) begin
                for (int c = 0; c < 4; c++) begin
                    int t = 4 * ((f + 1) % 8) + v % 4;
                    int a = 4 * ((f + 2) % 8) + c;
                    cr = $urandom;
                    cr[31 - 4*f -: 4] = 4'(v);
                    cr[31-t] = c[1]; cr[31-a] = c[0];
                    run("R4/R8", 1, cr, t, a, f, 8'($urandom), 4'($urandom));
                end
            end
        end

        // R5 and R7: every immediate against every mask.
        for (int imm = 0; imm < 256; imm++) begin
            for (int m = 0; m < 16; m++) begin
                int d = (imm + m) % 8;
                run("R5/R7", 2, $urandom, d, (d + 1) % 8, (d + 3) % 8, 8'(imm), 4'(m));
            end
        end

        // R6 and R7: every destination, source and table value.
        for (int dv = 0; dv < 16; dv++) begin
            for (int av = 0; av < 16; av++) begin
                for (int tv = 0; tv < 16; tv++) begin
                    int d = (dv + av) % 8;
                    int a = (d + 2) % 8;
                    int b = (d + 5) % 8;
                    cr = $urandom;
                    cr[31 - 4*d -: 4] = 4'(dv);
                    cr[31 - 4*a -: 4] = 4'(av);
                    cr[31 - 4*b -: 4] = 4'(tv);
                    run("R6/R7", 3, cr, d + 8 * (tv % 4), a, b, 8'($urandom), 4'(dv + tv));
                end
            end
        end

        // R9: sources aliased onto the destination read the old value.
        for (int n = 0; n < 64; n++) begin
            int t = n % 32;
            run("R9 bit", 0, $urandom, t, t, t, 8'($urandom), 4'h0);
            run("R9 bitbin", 1, $urandom, t, t, t / 4, 8'h00, 4'h0);
            run("R9 fld", 2, $urandom, n % 8, n % 8, n % 8, 8'($urandom), 4'($urandom));
            run("R9 fldbin", 3, $urandom, n % 8, (n + 1) % 8, n % 8, 8'h00, 4'($urandom));
        end

        // R2: idle cycles with changing inputs leave the output alone.
        run("R2 op", 2, 32'h1234_5678, 3, 4, 5, 8'hE8, 4'hF);
        held = cr_out;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            cr_in = $urandom; op = 2'(n); imm_lut = 8'($urandom); fld_mask = 4'hF;
            @(negedge clk);
            check("R2 hold", cr_out, held);
            check("R2 idle", {31'b0, out_valid}, 32'd0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule